// File: doc/BRIEF.md
# Context Sequencer with Branch-Class Prefetch

This block steps an array that takes a new configuration every step. It holds the address of the active context and drives a read port into program memory. It keeps the context that is executing in an active register, and a prefetched successor in a shadow register. Each context word carries its own branch class. The block uses that class to decide whether the successor is known early enough to fetch during execution. When it is, the fetch latency is hidden behind execution and no branch predictor is needed.

The array moves the block forward with a one-cycle step-enable pulse. At the same time it can present a jump request: a valid bit, a condition bit and a target address. When the needed context is not yet in the active register, the block raises a stall output. It accepts no step until that context has arrived.

Top module: `context_sequencer`

## Requirements
- R1: After reset the active address is 0 and the stall output is high. The first request to memory, issued on the clock edge after reset is released, is for address 0. Stall drops once that word has loaded.
- R2: A step-enable pulse that arrives while stall is high is ignored. The active address does not change.
- R3: Once raised, the memory request stays high with an unchanged address until a cycle in which the memory ready input is high. The read data is taken in that same cycle.
- R4: The context word layout is as follows. Bits [1:0] hold the branch class: 00 none, 01 unconditional, 10 conditional, 11 self-loop. Bits [ADDR_W+1:2] hold a target address. The upper PAY_W bits are payload. The whole word is presented on ctx_o.
- R5: Class none steps to address+1, and the target field is ignored. That successor is prefetched, so a step taken after the prefetch has completed leaves stall low.
- R6: Class unconditional steps to the context's own target field. That context is prefetched.
- R7: Class conditional issues no prefetch. On a step, the next address is the jump target when a jump request is valid with condition 1, and address+1 otherwise. Stall is high in the cycle after the step.
- R8: Class self-loop repeats on a step that has no valid jump request. The context stays active with stall low. A valid request with condition 0 exits to address+1, which was prefetched.
- R9: A step with a valid jump request whose condition is 1 goes to the request's target whatever the class. A held prefetch for a different address is discarded, and the target is fetched.
- R10: ctx_o changes only on an accepted step or when a fetched word fills an empty active register.
- R11: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_en_i | input | 1 | Step pulse from the array |
| jump_valid_i | input | 1 | Jump request present during this step |
| jump_cond_i | input | 1 | Jump condition: 1 means taken |
| jump_target_i | input | ADDR_W | Jump target address |
| mem_rdata_i | input | PAY_W+ADDR_W+2 | Program memory read data |
| mem_ready_i | input | 1 | Read data valid, completes the request |
| mem_addr_o | output | ADDR_W | Program memory address |
| mem_req_o | output | 1 | Program memory read request |
| ctx_o | output | PAY_W+ADDR_W+2 | Active context word |
| stall_o | output | 1 | Active context not yet loaded |

## Verification
The hardest case to reach is the collision between a prefetch and a redirect. A taken jump can arrive while the shadow register holds a successor, or while a fetch for the wrong address is still in flight. That stale data must then be dropped and not loaded. The stimulus reaches this case in two ways. A directed pass lets a prefetch complete under a fixed memory latency and then forces a taken jump. A sweep runs memory latencies 0 to 3 with varying idle gaps and jump patterns, so steps land both before and during outstanding fetches. A reference model in the bench follows the branch rules to predict the word that must appear after each step.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_JUMP = 2'b01,
    BR_COND = 2'b10,
    BR_LOOP = 2'b11
  } br_class_e;
endpackage

// File: rtl/ctx_next_addr.sv
module ctx_next_addr
  import ctx_seq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  br_class_e         cls_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] tgt_i,
  input  logic              jump_valid_i,
  input  logic              jump_cond_i,
  input  logic [ADDR_W-1:0] jump_target_i,
  output logic [ADDR_W-1:0] step_addr_o,
  output logic              stay_o,
  output logic              pf_ok_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  logic [ADDR_W-1:0] pc_inc;
  logic              taken;

  assign pc_inc = pc_i + ADDR_W'(1);
  assign taken  = jump_valid_i && jump_cond_i;

  always_comb begin
    stay_o      = 1'b0;
    step_addr_o = pc_inc;
    if (taken) begin
      step_addr_o = jump_target_i;
    end else begin
      unique case (cls_i)
        BR_JUMP: step_addr_o = tgt_i;
        BR_LOOP: stay_o      = !jump_valid_i;
        default: step_addr_o = pc_inc;
      endcase
    end
  end

  // successor known ahead of the step for every class but conditional
  assign pf_ok_o   = (cls_i != BR_COND);
  assign pf_addr_o = (cls_i == BR_JUMP) ? tgt_i : pc_inc;
endmodule

// File: rtl/ctx_fetch_port.sv
module ctx_fetch_port #(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              want_vld_i,
  input  logic [ADDR_W-1:0] want_addr_i,
  input  logic              mem_ready_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  logic              req_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      addr_q <= '0;
    end else if (req_q) begin
      if (mem_ready_i) req_q <= 1'b0;
    end else if (want_vld_i) begin
      req_q  <= 1'b1;
      addr_q <= want_addr_i;
    end
  end

  assign req_o  = req_q;
  assign addr_o = addr_q;
  assign done_o = req_q && mem_ready_i;

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !mem_ready_i |=> req_q && $stable(addr_q));
endmodule

// File: rtl/context_sequencer.sv
module context_sequencer
  import ctx_seq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int PAY_W  = 8,
  localparam int CTX_W = PAY_W + ADDR_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_en_i,
  input  logic              jump_valid_i,
  input  logic              jump_cond_i,
  input  logic [ADDR_W-1:0] jump_target_i,
  input  logic [CTX_W-1:0]  mem_rdata_i,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_req_o,
  output logic [CTX_W-1:0]  ctx_o,
  output logic              stall_o
);
  logic [ADDR_W-1:0] pc_q;
  logic [CTX_W-1:0]  act_q, shd_q;
  logic              act_vld_q, shd_vld_q;
  logic [ADDR_W-1:0] shd_addr_q;

  br_class_e         cls;
  logic [ADDR_W-1:0] tgt_f, step_addr, pf_addr, want_addr, rd_addr;
  logic              stay, pf_ok, want_vld, done, adv, to_active, to_shadow;

  assign cls   = br_class_e'(act_q[1:0]);
  assign tgt_f = act_q[ADDR_W+1:2];

  ctx_next_addr #(.ADDR_W(ADDR_W)) u_next (
    .cls_i         (cls),
    .pc_i          (pc_q),
    .tgt_i         (tgt_f),
    .jump_valid_i  (jump_valid_i),
    .jump_cond_i   (jump_cond_i),
    .jump_target_i (jump_target_i),
    .step_addr_o   (step_addr),
    .stay_o        (stay),
    .pf_ok_o       (pf_ok),
    .pf_addr_o     (pf_addr)
  );

  assign want_vld  = !act_vld_q || (pf_ok && !shd_vld_q);
  assign want_addr = act_vld_q ? pf_addr : pc_q;

  ctx_fetch_port #(.ADDR_W(ADDR_W)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .want_vld_i  (want_vld),
    .want_addr_i (want_addr),
    .mem_ready_i (mem_ready_i),
    .req_o       (mem_req_o),
    .addr_o      (rd_addr),
    .done_o      (done)
  );

  assign adv       = step_en_i && act_vld_q && !stay;
  // returning words are kept only if they still match what is needed
  assign to_active = done && !act_vld_q && (rd_addr == pc_q);
  assign to_shadow = done && act_vld_q && !adv && !shd_vld_q && pf_ok
                     && (rd_addr == pf_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q       <= '0;
      act_q      <= '0;
      act_vld_q  <= 1'b0;
      shd_q      <= '0;
      shd_vld_q  <= 1'b0;
      shd_addr_q <= '0;
    end else if (adv) begin
      pc_q      <= step_addr;
      shd_vld_q <= 1'b0;
      if (shd_vld_q && shd_addr_q == step_addr) begin
        act_q <= shd_q;
      end else if (done && rd_addr == step_addr) begin
        act_q <= mem_rdata_i;
      end else begin
        act_vld_q <= 1'b0;
      end
    end else begin
      if (to_active) begin
        act_q     <= mem_rdata_i;
        act_vld_q <= 1'b1;
      end
      if (to_shadow) begin
        shd_q      <= mem_rdata_i;
        shd_addr_q <= rd_addr;
        shd_vld_q  <= 1'b1;
      end
    end
  end

  assign mem_addr_o = rd_addr;
  assign ctx_o      = act_q;
  assign stall_o    = !act_vld_q;

  assert_stall_freeze_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(pc_q));
  assert_cond_no_prefetch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_vld_q && cls == BR_COND && !mem_req_o |=> !mem_req_o);
  assert_loop_keeps_ctx_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_en_i && act_vld_q && cls == BR_LOOP && !jump_valid_i |=> !stall_o && $stable(ctx_o));
  assert_ctx_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_vld_q && !step_en_i |=> $stable(ctx_o));
endmodule

// File: tb/context_sequencer_tb.sv
module context_sequencer_tb_top;
  localparam int ADDR_W = 4;
  localparam int PAY_W  = 8;
  localparam int CTX_W  = PAY_W + ADDR_W + 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              step_en_i = 1'b0;
  logic              jump_valid_i = 1'b0;
  logic              jump_cond_i = 1'b0;
  logic [ADDR_W-1:0] jump_target_i = '0;
  logic [CTX_W-1:0]  mem_rdata_i = '0;
  logic              mem_ready_i = 1'b0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic              mem_req_o;
  logic [CTX_W-1:0]  ctx_o;
  logic              stall_o;

  int n_tests = 0;
  int n_fail  = 0;
  int lat     = 2;
  int wait_cnt = 0;
  int cycles  = 0;
  logic [ADDR_W-1:0] exp_pc = '0;

  context_sequencer #(.ADDR_W(ADDR_W), .PAY_W(PAY_W)) dut_i (.*);

  always #5 clk_i = ~clk_i;

  // program image, R4 layout: [1:0] class, [ADDR_W+1:2] target, payload above
  function automatic logic [1:0] cls_of(input logic [ADDR_W-1:0] a);
    case (a)
      4'd2, 4'd9: return 2'b01;
      4'd6, 4'd11: return 2'b10;
      4'd7, 4'd13: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] tgt_of(input logic [ADDR_W-1:0] a);
    if (a == 4'd2) return 4'd6;
    if (a == 4'd9) return 4'd0;
    return a ^ 4'd5;
  endfunction

  function automatic logic [CTX_W-1:0] img(input logic [ADDR_W-1:0] a);
    return {~a, a, tgt_of(a), cls_of(a)};
  endfunction

  function automatic logic [ADDR_W-1:0] ref_next(input logic [ADDR_W-1:0] pc,
      input logic jv, input logic jc, input logic [ADDR_W-1:0] jt);
    if (jv && jc) return jt;
    case (cls_of(pc))
      2'b01: return tgt_of(pc);
      2'b11: return jv ? pc + 4'd1 : pc;
      default: return pc + 4'd1;
    endcase
  endfunction

  // memory model: ready after lat waiting cycles
  always @(negedge clk_i) begin
    cycles++;
    if (mem_req_o && wait_cnt >= lat) begin
      mem_ready_i = 1'b1;
      mem_rdata_i = img(mem_addr_o);
      wait_cnt = 0;
    end else begin
      mem_ready_i = 1'b0;
      if (mem_req_o) wait_cnt++;
    end
  end

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk_i) if (cycles > 150000) begin
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    finish_run();
  end

  task automatic wait_ready();
    for (int k = 0; k < 100 && stall_o; k++) @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk_i);
  endtask

  task automatic do_step(input logic jv, input logic jc, input logic [ADDR_W-1:0] jt);
    @(negedge clk_i);
    step_en_i = 1'b1; jump_valid_i = jv; jump_cond_i = jc; jump_target_i = jt;
    exp_pc = ref_next(exp_pc, jv, jc, jt);
    @(negedge clk_i);
    step_en_i = 1'b0; jump_valid_i = 1'b0; jump_cond_i = 1'b0;
  endtask

  initial begin
    idle(2);
    chk(stall_o == 1'b1, "R1 stall in reset", stall_o, 1);
    chk(mem_req_o == 1'b0, "R1 no request in reset", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_req_o && mem_addr_o == 0, "R1 first fetch addr 0", mem_addr_o, 0);
    // R2: step pulse while stalled is ignored
    step_en_i = 1'b1; jump_valid_i = 1'b1; jump_cond_i = 1'b1; jump_target_i = 4'd9;
    @(negedge clk_i);
    step_en_i = 1'b0; jump_valid_i = 1'b0; jump_cond_i = 1'b0;
    wait_ready();
    chk(ctx_o == img(0), "R2 step ignored during stall", ctx_o, img(0));
    // R5 none class, prefetched
    idle(8); do_step(0, 0, 0);
    chk(!stall_o, "R5 hidden latency", stall_o, 0);
    chk(ctx_o == img(1), "R5 next is pc+1", ctx_o, img(1));
    idle(8); do_step(0, 0, 0);
    chk(ctx_o == img(2), "R5 step to 2", ctx_o, img(2));
    // R6 unconditional to own target
    idle(8); do_step(0, 0, 0);
    chk(!stall_o && ctx_o == img(6), "R6 unconditional target prefetched", ctx_o, img(6));
    // R7 conditional: no prefetch, stall after step
    idle(8);
    chk(!mem_req_o, "R7 no prefetch on conditional", mem_req_o, 0);
    do_step(1, 1, 4'd7);
    chk(stall_o, "R7 stall after conditional step", stall_o, 1);
    wait_ready();
    chk(ctx_o == img(7), "R7 taken target", ctx_o, img(7));
    // R8 self-loop
    idle(8); do_step(0, 0, 0);
    chk(!stall_o && ctx_o == img(7), "R8 loop repeats", ctx_o, img(7));
    do_step(1, 0, 4'd3);
    chk(!stall_o && ctx_o == img(8), "R8 loop exit prefetched", ctx_o, img(8));
    // R9 taken jump discards held prefetch
    idle(8); do_step(1, 1, 4'd15);
    chk(stall_o, "R9 shadow discarded", stall_o, 1);
    wait_ready();
    chk(ctx_o == img(15), "R9 jump target loaded", ctx_o, img(15));
    // R11 wrap
    idle(8); do_step(0, 0, 0);
    chk(!stall_o && ctx_o == img(0), "R11 wrap to 0", ctx_o, img(0));
    // sweep over latency, gaps and jump patterns
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int i = 0; i < 40; i++) begin
        wait_ready();
        idle(i % 3);
        do_step(((i * 3 + l) % 4) == 0, (i % 2) == 0, ADDR_W'((i * 5 + l) % DEPTH));
        wait_ready();
        chk(ctx_o == img(exp_pc), "R5 R6 R7 R8 R9 sweep", ctx_o, img(exp_pc));
      end
    end
    finish_run();
  end
endmodule